// File: doc/BRIEF.md
# Ring interrupt status unit

This unit collects completion and overflow events from a set of DMA channels and presents them to host software as packed status words and enable words behind a plain register read/write port. Every channel can report three event kinds: transmit completion, receive completion and receive overflow. The events are latched until software clears them.

Software sets one enable bit per channel for each direction. A single level-sensitive interrupt line is raised when an enabled event is pending. Overflow events have no enable bits of their own. They follow the receive enable of their channel.

When software starts servicing the interrupt, the unit disarms. It arms again only after software has read every status word, including words that hold only disabled channels. By default a status read clears the word it returns. A mode bit can instead select explicit write-one-to-clear.

Top module: `rirq_unit`

## Requirements
- R1: A one-cycle pulse on a channel's event input sets one status bit. For channel c, the bit position is c for transmit completion, NCH+c for receive completion and 2*NCH+c for receive overflow. The bit lives in status word position/32 at bit position%32. It stays set until it is cleared.
- R2: Status word i (0 <= i < ceil(3*NCH/32)) is at word address i. A read returns its contents on `reg_rdata_o` in the cycle after the read strobe. Padding bits above 3*NCH and reads of unmapped addresses return zero. `reg_rdata_o` changes only on a read.
- R3: While automatic clearing is on, a status read clears the whole word. An event that arrives in the same cycle as that clearing read is kept pending and shows on the next read.
- R4: Enable word j (0 <= j < ceil(2*NCH/32)) is at word address 64+j. The enable bits are packed with receive enables at bit positions 0..NCH-1 and transmit enables at NCH..2*NCH-1. A written enable word reads back masked to the 2*NCH defined bits.
- R5: `irq_o` is high exactly when the unit is armed and at least one of these is pending:
  - a transmit bit whose transmit enable is set;
  - a receive bit whose receive enable is set;
  - an overflow bit whose receive enable is set.
- R6: A receive overflow event raises the interrupt when only the receive enable of that channel is set.
- R7: A status-word read while `irq_o` is high disarms the unit and drops `irq_o`. The unit stays disarmed until every status word has been read since the disarm, in any order. It then re-arms in the same cycle as the last read. `irq_o` rises again at once if enabled events are still pending.
- R8: Word address 128 is read-only. It returns the channel count NCH in bits 10:0 and zero above. Writes to it have no effect.
- R9: Bit 2 of word address 129 selects automatic clearing and resets to 1. With the bit at 0, status reads do not clear, and writing ones to a status word clears those bits. With the bit at 1, writes to status words have no effect.
- R10: After reset the following hold:
  - all status bits read zero;
  - all enable bits read zero;
  - the unit is armed;
  - `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_done_i | input | NCH | Transmit completion pulses, one per channel |
| rx_done_i | input | NCH | Receive completion pulses, one per channel |
| rx_ovf_i | input | NCH | Receive overflow pulses, one per channel |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the unit with NCH = 22 and ADDR_W = 8. This gives three status words and two enable words. The receive field straddles status words 0 and 1, and the overflow field straddles words 1 and 2, so the word-boundary packing is exercised. With three words the re-arm rule can be checked with partial and out-of-order read sequences. The third status word carries padding bits, and the second enable word is only partly defined, so both masking paths are checked as well.

// File: rtl/rirq_pkg.sv
package rirq_pkg;

    localparam int WORD_W      = 32;
    localparam int CHCNT_W     = 11;
    localparam int AUTOCLR_BIT = 2;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_STS  = 3'd1,
        RG_ENB  = 3'd2,
        RG_CAP  = 3'd3,
        RG_MISC = 3'd4
    } reg_kind_e;

    function automatic int words_for(input int nbits);
        return (nbits + WORD_W - 1) / WORD_W;
    endfunction

    function automatic int idx_width(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        if (m < 2) m = 2;
        return $clog2(m);
    endfunction

endpackage

// File: rtl/rirq_status_bank.sv
module rirq_status_bank
    import rirq_pkg::*;
#(
    parameter int NCH   = 12,
    parameter int NSW   = 2,
    parameter int IDX_W = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        ev_tx_i,
    input  logic [NCH-1:0]        ev_rx_i,
    input  logic [NCH-1:0]        ev_ovf_i,
    input  logic                  clr_en_i,
    input  logic [IDX_W-1:0]      clr_idx_i,
    input  logic [WORD_W-1:0]     clr_bits_i,
    output logic [NSW*WORD_W-1:0] sts_o
);

    localparam int TOT = NSW * WORD_W;
    localparam int FLD = 3 * NCH;

    typedef struct packed {
        logic [TOT-1:0] sts;
    } bank_t;

    bank_t          s_d, s_q;
    logic [TOT-1:0] ev_vec;
    logic [TOT-1:0] clr_vec;

    always_comb begin
        ev_vec          = '0;
        ev_vec[FLD-1:0] = {ev_ovf_i, ev_rx_i, ev_tx_i};
        clr_vec         = '0;
        for (int w = 0; w < NSW; w++) begin
            if (clr_en_i && (clr_idx_i == IDX_W'(w))) begin
                clr_vec[w*WORD_W +: WORD_W] = clr_bits_i;
            end
        end
        s_d     = s_q;
        s_d.sts = (s_q.sts & ~clr_vec) | ev_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sts_o = s_q.sts;

    // R3: an incoming event is always latched, even against a clear
    p_event_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_vec) |=> ((sts_o & $past(ev_vec)) == $past(ev_vec)));

    // R3: cleared bits without a simultaneous event read zero afterwards
    p_clear_applied_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_vec) |=> ((sts_o & $past(clr_vec & ~ev_vec)) == '0));

endmodule

// File: rtl/rirq_arm_ctrl.sv
module rirq_arm_ctrl #(
    parameter int NSW   = 2,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             irq_now_i,
    output logic             armed_o
);

    typedef struct packed {
        logic           armed;
        logic [NSW-1:0] seen;
    } arm_t;

    arm_t           s_d, s_q;
    logic [NSW-1:0] seen_n;

    always_comb begin
        s_d    = s_q;
        seen_n = s_q.armed ? '0 : s_q.seen;
        for (int w = 0; w < NSW; w++) begin
            if (idx_i == IDX_W'(w)) seen_n[w] = 1'b1;
        end
        if (rd_i && (irq_now_i || !s_q.armed)) begin
            if (&seen_n) begin
                s_d.armed = 1'b1;
                s_d.seen  = '0;
            end else begin
                s_d.armed = 1'b0;
                s_d.seen  = seen_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.armed <= 1'b1;
            s_q.seen  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign armed_o = s_q.armed;

    // R7: re-arming only happens on a status read
    p_rearm_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_o) |-> $past(rd_i));

    generate
        if (NSW > 1) begin : g_multi
            // R7: servicing a raised interrupt disarms the unit
            p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_i && irq_now_i) |=> !armed_o);
        end
    endgenerate

endmodule

// File: rtl/rirq_regfile.sv
module rirq_regfile
    import rirq_pkg::*;
#(
    parameter int NCH    = 12,
    parameter int NSW    = 2,
    parameter int NEW    = 1,
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_i,
    input  logic                  wr_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [WORD_W-1:0]     wdata_i,
    input  logic [NSW*WORD_W-1:0] sts_i,
    output logic [WORD_W-1:0]     rdata_o,
    output logic [2*NCH-1:0]      en_o,
    output logic                  sts_rd_o,
    output logic [IDX_W-1:0]      sts_idx_o,
    output logic                  clr_en_o,
    output logic [WORD_W-1:0]     clr_bits_o
);

    localparam int ENB_BASE  = 1 << (ADDR_W - 2);
    localparam int CAP_ADDR  = 1 << (ADDR_W - 1);
    localparam int MISC_ADDR = CAP_ADDR + 1;
    localparam int EFLD      = 2 * NCH;

    typedef struct packed {
        logic [EFLD-1:0]   en;
        logic              autoclr;
        logic [WORD_W-1:0] rdata;
    } regs_t;

    regs_t             s_d, s_q;
    reg_kind_e         kind;
    logic [ADDR_W-1:0] off;

    always_comb begin
        kind = RG_NONE;
        off  = '0;
        if (addr_i < ADDR_W'(ENB_BASE)) begin
            off = addr_i;
            if (addr_i < ADDR_W'(NSW)) kind = RG_STS;
        end else if (addr_i < ADDR_W'(CAP_ADDR)) begin
            off = addr_i - ADDR_W'(ENB_BASE);
            if (off < ADDR_W'(NEW)) kind = RG_ENB;
        end else if (addr_i == ADDR_W'(CAP_ADDR)) begin
            kind = RG_CAP;
        end else if (addr_i == ADDR_W'(MISC_ADDR)) begin
            kind = RG_MISC;
        end
    end

    always_comb begin
        s_d        = s_q;
        sts_rd_o   = rd_i && (kind == RG_STS);
        sts_idx_o  = off[IDX_W-1:0];
        clr_en_o   = 1'b0;
        clr_bits_o = '0;

        if (sts_rd_o && s_q.autoclr) begin
            clr_en_o   = 1'b1;
            clr_bits_o = '1;
        end
        if (wr_i && (kind == RG_STS) && !s_q.autoclr) begin
            clr_en_o   = 1'b1;
            clr_bits_o = wdata_i;
        end

        if (wr_i && (kind == RG_ENB)) begin
            for (int b = 0; b < EFLD; b++) begin
                if (off == ADDR_W'(b / WORD_W)) s_d.en[b] = wdata_i[b % WORD_W];
            end
        end
        if (wr_i && (kind == RG_MISC)) begin
            s_d.autoclr = wdata_i[AUTOCLR_BIT];
        end

        if (rd_i) begin
            s_d.rdata = '0;
            case (kind)
                RG_STS: begin
                    for (int w = 0; w < NSW; w++) begin
                        if (off == ADDR_W'(w)) s_d.rdata = sts_i[w*WORD_W +: WORD_W];
                    end
                end
                RG_ENB: begin
                    for (int b = 0; b < EFLD; b++) begin
                        if (off == ADDR_W'(b / WORD_W)) s_d.rdata[b % WORD_W] = s_q.en[b];
                    end
                end
                RG_CAP:  s_d.rdata[CHCNT_W-1:0] = CHCNT_W'(NCH);
                RG_MISC: s_d.rdata[AUTOCLR_BIT] = s_q.autoclr;
                default: s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.en      <= '0;
            s_q.autoclr <= 1'b1;
            s_q.rdata   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o = s_q.rdata;
    assign en_o    = s_q.en;

    // R8: the capability word always reports the channel count
    p_cap_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (kind == RG_CAP)) |=> (rdata_o == WORD_W'(NCH)));

    // R4: enables change only through an enable-word write
    p_enable_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && (kind == RG_ENB)) |=> $stable(en_o));

    // R2: read data holds between reads
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/rirq_unit.sv
module rirq_unit
    import rirq_pkg::*;
#(
    parameter int NCH    = 12,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    tx_done_i,
    input  logic [NCH-1:0]    rx_done_i,
    input  logic [NCH-1:0]    rx_ovf_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);

    localparam int NSW   = words_for(3 * NCH);
    localparam int NEW   = words_for(2 * NCH);
    localparam int IDX_W = idx_width(NSW, NEW);
    localparam int FLD   = 3 * NCH;

    logic [NSW*WORD_W-1:0] sts;
    logic [2*NCH-1:0]      en;
    logic [FLD-1:0]        gate;
    logic                  sts_rd;
    logic [IDX_W-1:0]      sts_idx;
    logic                  clr_en;
    logic [WORD_W-1:0]     clr_bits;
    logic                  armed;
    logic                  hit;

    rirq_status_bank #(.NCH(NCH), .NSW(NSW), .IDX_W(IDX_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_tx_i    (tx_done_i),
        .ev_rx_i    (rx_done_i),
        .ev_ovf_i   (rx_ovf_i),
        .clr_en_i   (clr_en),
        .clr_idx_i  (sts_idx),
        .clr_bits_i (clr_bits),
        .sts_o      (sts)
    );

    rirq_regfile #(.NCH(NCH), .NSW(NSW), .NEW(NEW), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (reg_rd_i),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .sts_i      (sts),
        .rdata_o    (reg_rdata_o),
        .en_o       (en),
        .sts_rd_o   (sts_rd),
        .sts_idx_o  (sts_idx),
        .clr_en_o   (clr_en),
        .clr_bits_o (clr_bits)
    );

    // overflow shares the receive enable of its channel
    always_comb begin
        gate = {en[NCH-1:0], en[NCH-1:0], en[2*NCH-1:NCH]};
        hit  = |(sts[FLD-1:0] & gate);
    end

    assign irq_o = armed && hit;

    rirq_arm_ctrl #(.NSW(NSW), .IDX_W(IDX_W)) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_i      (sts_rd),
        .idx_i     (sts_idx),
        .irq_now_i (irq_o),
        .armed_o   (armed)
    );

    // R5: no interrupt while every source is disabled
    p_quiet_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq_o);

endmodule

// File: tb/rirq_unit_bench.sv
`timescale 1ns/1ps
module rirq_unit_bench;

    localparam int NCH    = 22;
    localparam int ADDR_W = 8;
    localparam int NSW    = (3 * NCH + 31) / 32;
    localparam int NEW    = (2 * NCH + 31) / 32;
    localparam int A_ENB  = 64;
    localparam int A_CAP  = 128;
    localparam int A_MISC = 129;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    tx_done = '0, rx_done = '0, rx_ovf = '0;
    logic              reg_rd = 1'b0, reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq;

    always #2.5 clk = ~clk;

    rirq_unit #(.NCH(NCH), .ADDR_W(ADDR_W)) u_rirq_unit (
        .clk(clk), .rst_n(rst_n),
        .tx_done_i(tx_done), .rx_done_i(rx_done), .rx_ovf_i(rx_ovf),
        .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    logic [3*NCH-1:0] ms;
    logic [2*NCH-1:0] me;
    logic             mac;
    logic             marmed;
    logic [NSW-1:0]   mseen;
    int               checks = 0;
    int               fails = 0;
    bit               done = 1'b0;

    function automatic logic [31:0] sts_word(input int i);
        logic [31:0] r = '0;
        for (int b = 0; b < 32; b++) if (i*32 + b < 3*NCH) r[b] = ms[i*32 + b];
        return r;
    endfunction

    function automatic logic [31:0] en_word(input int i);
        logic [31:0] r = '0;
        for (int b = 0; b < 32; b++) if (i*32 + b < 2*NCH) r[b] = me[i*32 + b];
        return r;
    endfunction

    function automatic logic m_irq();
        logic [3*NCH-1:0] g;
        g = {me[NCH-1:0], me[NCH-1:0], me[2*NCH-1:NCH]};
        return marmed && (|(ms & g));
    endfunction

    // 1 status, 2 enable, 3 cap, 4 misc, 0 unmapped
    function automatic int kind_of(input int a);
        if (a < A_ENB) return (a < NSW) ? 1 : 0;
        if (a < A_CAP) return (a - A_ENB < NEW) ? 2 : 0;
        if (a == A_CAP) return 3;
        if (a == A_MISC) return 4;
        return 0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic rd, input logic wr, input int addr, input logic [31:0] wd,
                         input logic [NCH-1:0] t, input logic [NCH-1:0] r, input logic [NCH-1:0] o,
                         input string tag);
        logic [31:0] exp_rd;
        logic [3*NCH-1:0] clr;
        logic old_irq;
        logic [NSW-1:0] sn;
        int k;
        string rtag, itag;
        k = kind_of(addr);
        @(negedge clk);
        reg_rd = rd; reg_wr = wr; reg_addr = ADDR_W'(addr); reg_wdata = wd;
        tx_done = t; rx_done = r; rx_ovf = o;
        exp_rd = '0;
        case (k)
            1: exp_rd = sts_word(addr);
            2: exp_rd = en_word(addr - A_ENB);
            3: exp_rd = 32'(NCH);
            4: exp_rd = {29'd0, mac, 2'b00};
            default: exp_rd = '0;
        endcase
        old_irq = m_irq();
        @(posedge clk);
        #1;
        clr = '0;
        for (int b = 0; b < 3*NCH; b++) begin
            if (k == 1 && b / 32 == addr) begin
                if (rd && mac) clr[b] = 1'b1;
                if (wr && !mac) clr[b] = wd[b % 32];
            end
        end
        ms = (ms & ~clr) | {o, r, t};
        if (wr && k == 2)
            for (int b = 0; b < 2*NCH; b++) if (b / 32 == addr - A_ENB) me[b] = wd[b % 32];
        if (wr && k == 4) mac = wd[2];
        if (rd && k == 1 && (old_irq || !marmed)) begin
            sn = marmed ? '0 : mseen;
            sn[addr] = 1'b1;
            if (&sn) begin marmed = 1'b1; mseen = '0; end
            else begin marmed = 1'b0; mseen = sn; end
        end
        rtag = (k == 2) ? "R4" : (k == 3) ? "R8" : (k == 4) ? "R9" : "R2";
        itag = "R5";
        if (tag != "") begin rtag = tag; itag = tag; end
        if (rd) chk({rtag, " rdata"}, reg_rdata, exp_rd);
        chk({itag, " irq"}, {31'd0, irq}, {31'd0, m_irq()});
    endtask

    task automatic rd_word(input int a, input string tag);
        cycle(1'b1, 1'b0, a, '0, '0, '0, '0, tag);
    endtask

    task automatic wr_word(input int a, input logic [31:0] d, input string tag);
        cycle(1'b0, 1'b1, a, d, '0, '0, '0, tag);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [NCH-1:0] one;
        one = NCH'(1);
        ms = '0; me = '0; mac = 1'b1; marmed = 1'b1; mseen = '0;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state at the ports
        chk("R10 irq after reset", {31'd0, irq}, 32'd0);
        for (int i = 0; i < NSW; i++) rd_word(i, "R10");
        for (int i = 0; i < NEW; i++) rd_word(A_ENB + i, "R10");
        rd_word(A_MISC, "R9");
        rd_word(A_CAP, "R8");

        // R8: capability word ignores writes
        wr_word(A_CAP, 32'hFFFF_FFFF, "R8");
        rd_word(A_CAP, "R8");

        // R1: packing across word boundaries, no enables so no interrupt
        cycle(1'b0, 1'b0, 0, '0, one << 3, one << 21, one << 0, "R1");
        for (int i = 0; i < NSW; i++) rd_word(i, "R1");

        // R6: overflow follows the receive enable
        wr_word(A_ENB, 32'h0000_0020, "R6");
        cycle(1'b0, 1'b0, 0, '0, '0, '0, one << 5, "R6");
        chk("R6 irq raised", {31'd0, irq}, 32'd1);

        // R7: disarm on service, re-arm after all words read
        rd_word(0, "R7");
        chk("R7 irq dropped", {31'd0, irq}, 32'd0);
        cycle(1'b0, 1'b0, 0, '0, '0, one << 5, '0, "R7");
        chk("R7 held while disarmed", {31'd0, irq}, 32'd0);
        rd_word(2, "R7");
        rd_word(2, "R7");
        chk("R7 partial reads keep disarmed", {31'd0, irq}, 32'd0);
        rd_word(1, "R7");
        chk("R7 re-armed with pending", {31'd0, irq}, 32'd1);
        for (int i = 0; i < NSW; i++) rd_word(i, "R7");

        // R3: event in the same cycle as a clearing read
        cycle(1'b1, 1'b0, 0, '0, one << 2, '0, '0, "R3");
        rd_word(0, "R3");
        chk("R3 bit kept", reg_rdata & 32'h4, 32'h4);

        // R9: write-one-to-clear mode and ignored writes in auto mode
        wr_word(A_MISC, 32'h0, "R9");
        cycle(1'b0, 1'b0, 0, '0, one << 1, '0, '0, "R9");
        rd_word(0, "R9");
        rd_word(0, "R9");
        wr_word(0, 32'h2, "R9");
        rd_word(0, "R9");
        wr_word(A_MISC, 32'h4, "R9");
        cycle(1'b0, 1'b0, 0, '0, one << 4, '0, '0, "R9");
        wr_word(0, 32'hFFFF_FFFF, "R9");
        rd_word(0, "R9");

        // R4: enable read-back masking
        wr_word(A_ENB + 1, 32'hFFFF_FFFF, "R4");
        rd_word(A_ENB + 1, "R4");
        chk("R4 masked width", reg_rdata, 32'h0000_0FFF);
        wr_word(A_ENB + 1, 32'h0, "R4");

        // random mix, R2 and R5 checked every cycle
        for (int n = 0; n < 4000; n++) begin
            int a, sel, p;
            logic rd, wr;
            sel = int'($urandom % 8);
            case (sel)
                0, 1, 2: a = int'($urandom % 4);
                3:       a = A_ENB + int'($urandom % 3);
                4:       a = A_CAP;
                5:       a = A_MISC;
                6:       a = int'($urandom % 256);
                default: a = int'($urandom % 3);
            endcase
            p  = int'($urandom % 10);
            rd = (p < 3);
            wr = (p == 3);
            cycle(rd, wr, a, $urandom,
                  NCH'($urandom & $urandom & $urandom),
                  NCH'($urandom & $urandom & $urandom),
                  NCH'($urandom & $urandom & $urandom & $urandom), "");
        end

        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0;
        tx_done = '0; rx_done = '0; rx_ovf = '0;
        report();
        $finish;
    end

endmodule